// File: doc/BRIEF.md
# Flash Write Status Reporter

This block stands beside a flash array and its command decoder. It models how long the internal write engine stays busy and what a host sees when it reads the array during that time. The decoder issues a one-cycle start pulse together with an operation code and the word being programmed. The block then holds a busy flag for a cycle count fixed by a parameter for each operation. While busy, every array read carries two status bits. Bit 7 reports progress through its polarity, and bit 6 changes on each new read access. When the operation ends, reads pass the array word through unchanged.

A host can therefore poll any address until bit 7 shows the true data or until bit 6 stops changing. When the decoder has put the device in identification mode and no operation is running, reads at word addresses 0 and 1 return two constant identification words. The array storage and the command decoding sit outside this block.

Top module: `flash_wstat`

## Requirements
- R1: After reset, busy_o is 0 and rd_data_o equals array_data_i.
- R2: A start with op_i = 2'b00 (word program) while idle raises busy_o at the clock edge that samples the start. busy_o then stays high for exactly PROG_CYCLES clock cycles.
- R3: A start with op_i = 2'b01 (sector erase) keeps busy_o high for exactly SECT_CYCLES cycles. A start with op_i = 2'b10 (chip erase) keeps it high for exactly CHIP_CYCLES cycles.
- R4: A start with op_i = 2'b11 is reserved and has no effect: busy_o stays 0.
- R5: A start that arrives while busy_o is high is ignored. busy_o falls at the time set by the operation already running.
- R6: While a program is busy, rd_data_o[7] is the complement of bit 7 of the program word latched at the start.
- R7: While an erase is busy, rd_data_o[7] is 0.
- R8: While busy, rd_data_o[6] reads as opposite values on two consecutive read accesses. A read access is counted on the rising edge of rd_i, so holding rd_i high across several cycles counts as one access.
- R9: While busy, every rd_data_o bit other than 7 and 6 equals the same bit of array_data_i.
- R10: Once busy_o is 0, rd_data_o equals array_data_i on every bit, including bits 7 and 6, outside identification reads. Bit 6 no longer changes between reads.
- R11: With id_mode_i high and busy_o low, a read at rd_addr_i = 0 returns MFR_ID and a read at rd_addr_i = 1 returns DEV_ID. Any other address returns array_data_i.
- R12: While busy, status reads take priority over identification mode. Bit 7 shows status even at rd_addr_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches an operation |
| op_i | input | 2 | Operation code: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| prog_data_i | input | DATA_W | Word being programmed |
| rd_i | input | 1 | Read strobe; its rising edge marks one read access |
| rd_addr_i | input | ADDR_W | Word address of the current read |
| array_data_i | input | DATA_W | Word read from the array at rd_addr_i |
| id_mode_i | input | 1 | Identification mode is active |
| busy_o | output | 1 | Internal operation in progress |
| rd_data_o | output | DATA_W | Read word presented to the host |

## Verification
The hardest case to reach from the ports is a second start that arrives in the middle of a busy window. Busy must end on the first operation's schedule and must not be restarted by the second start. The bench raises a chip-erase start a few cycles into a program and counts the busy cycles at each falling edge. It then checks that the count equals the program length. A second hard case is a read strobe held high for several cycles. The bench holds rd_i high, then issues a fresh strobe, and checks that bit 6 changed only once across the two accesses.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_NONE = 2'b11
  } fws_op_e;

  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
endpackage

// File: rtl/fws_engine.sv
module fws_engine
  import fws_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 1000,
  parameter int unsigned SECT_CYCLES = 1250000,
  parameter int unsigned CHIP_CYCLES = 5000000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  fws_op_e op_i,
  input  logic    pol_i,
  output logic    busy_o,
  output logic    erase_o,
  output logic    pol_o
);
  localparam int unsigned MAX_A  = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int unsigned MAX_CY = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
  localparam int unsigned CNT_W  = $clog2(MAX_CY + 1);

  logic [CNT_W-1:0] cnt_q, load_val;
  logic             busy_q, erase_q, pol_q;

  always_comb begin
    unique case (op_i)
      OP_SECT: load_val = CNT_W'(SECT_CYCLES - 1);
      OP_CHIP: load_val = CNT_W'(CHIP_CYCLES - 1);
      default: load_val = CNT_W'(PROG_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      pol_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      if (start_i && op_i != OP_NONE) begin
        busy_q  <= 1'b1;
        erase_q <= (op_i != OP_PROG);
        pol_q   <= pol_i;
        cnt_q   <= load_val;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign erase_o = erase_q;
  assign pol_o   = pol_q;

  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  assert_no_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  assert_reserved_op_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i && op_i == OP_NONE) |=> !busy_q);
endmodule

// File: rtl/fws_toggle.sv
module fws_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_i,
  output logic tgl_o
);
  logic rd_q, tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
      // advance only on a new read access during an operation
      if (busy_i && rd_i && !rd_q) tgl_q <= ~tgl_q;
    end
  end

  assign tgl_o = tgl_q;

  assert_tgl_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(tgl_q));
  assert_tgl_held_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_q) |=> $stable(tgl_q));
endmodule

// File: rtl/fws_rd_mux.sv
module fws_rd_mux
  import fws_pkg::*;
#(
  parameter int unsigned    DATA_W = 16,
  parameter int unsigned    ADDR_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h3C71
) (
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              pol_i,
  input  logic              tgl_i,
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = array_data_i;
    if (busy_i) begin
      rd_data_o[POLL_BIT] = erase_i ? 1'b0 : ~pol_i;
      rd_data_o[TGL_BIT]  = tgl_i;
    end else if (id_mode_i) begin
      if (rd_addr_i == '0)                rd_data_o = MFR_ID;
      else if (rd_addr_i == ADDR_W'(1))   rd_data_o = DEV_ID;
    end
  end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import fws_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned PROG_CYCLES = 1000,
  parameter int unsigned SECT_CYCLES = 1250000,
  parameter int unsigned CHIP_CYCLES = 5000000,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h3C71
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              id_mode_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic busy, erase, pol, tgl;

  fws_engine #(
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .CHIP_CYCLES(CHIP_CYCLES)
  ) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_i   (fws_op_e'(op_i)),
    .pol_i  (prog_data_i[POLL_BIT]),
    .busy_o (busy),
    .erase_o(erase),
    .pol_o  (pol)
  );

  fws_toggle u_toggle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy),
    .rd_i  (rd_i),
    .tgl_o (tgl)
  );

  fws_rd_mux #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .MFR_ID(MFR_ID),
    .DEV_ID(DEV_ID)
  ) u_mux (
    .busy_i      (busy),
    .erase_i     (erase),
    .pol_i       (pol),
    .tgl_i       (tgl),
    .id_mode_i   (id_mode_i),
    .rd_addr_i   (rd_addr_i),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o)
  );

  assign busy_o = busy;

  assert_erase_poll_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && erase) |-> !rd_data_o[POLL_BIT]);
  assert_pass_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !id_mode_i) |-> rd_data_o == array_data_i);
  assert_other_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rd_data_o[DATA_W-1:POLL_BIT+1] == array_data_i[DATA_W-1:POLL_BIT+1]
                && rd_data_o[TGL_BIT-1:0] == array_data_i[TGL_BIT-1:0]));
endmodule

// File: tb/flash_wstat_bench.sv
module flash_wstat_bench;
  localparam int CLK_T = 10;
  localparam int PROG_N = 24;
  localparam int SECT_N = 40;
  localparam int CHIP_N = 60;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h3C71;

  logic clk = 0, rst_n = 0, start = 0, rd = 0, id_mode = 0;
  logic [1:0]  op = 2'b00;
  logic [15:0] pdata = '0, rd_addr = '0, arr = 16'h5A3C;
  logic        busy;
  logic [15:0] rdata;
  int checks = 0, fails = 0;

  always #(CLK_T/2) clk = ~clk;

  flash_wstat #(
    .DATA_W(16), .ADDR_W(16),
    .PROG_CYCLES(PROG_N), .SECT_CYCLES(SECT_N), .CHIP_CYCLES(CHIP_N),
    .MFR_ID(MFR), .DEV_ID(DEV)
  ) u_flash_wstat (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .prog_data_i(pdata), .rd_i(rd), .rd_addr_i(rd_addr),
    .array_data_i(arr), .id_mode_i(id_mode),
    .busy_o(busy), .rd_data_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1; rd_addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic launch(input logic [1:0] o, input logic [15:0] pd);
    @(negedge clk); start = 1; op = o; pdata = pd;
    #1 chk(busy == 0, "R2 busy before edge", busy, 0);
    @(negedge clk); start = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rdata == arr, "R1 data", rdata, arr);
    rst_n = 1;
  endtask

  task automatic t_timing();
    int n;
    launch(2'b00, 16'h1234);
    chk(busy == 1, "R2 busy after edge", busy, 1);
    count_busy(n); chk(n == PROG_N, "R2 program length", n, PROG_N);
    launch(2'b01, 16'h0);
    count_busy(n); chk(n == SECT_N, "R3 sector length", n, SECT_N);
    launch(2'b10, 16'h0);
    count_busy(n); chk(n == CHIP_N, "R3 chip length", n, CHIP_N);
  endtask

  task automatic t_reserved();
    launch(2'b11, 16'h0);
    chk(busy == 0, "R4 reserved op", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R4 reserved op later", busy, 0);
  endtask

  task automatic t_restart();
    int n = 0;
    launch(2'b00, 16'h0);
    while (busy) begin
      n++;
      if (n == 3) begin start = 1; op = 2'b10; end
      @(negedge clk);
      start = 0;
    end
    chk(n == PROG_N, "R5 start during busy ignored", n, PROG_N);
  endtask

  task automatic t_prog_status();
    logic [15:0] d1, d2, d3, d4;
    arr = 16'hA5C3;
    launch(2'b00, 16'h1234);
    do_read(16'h0042, d1);
    chk(d1[7] == 1'b1, "R6 bit7 complement of 0", d1[7], 1);
    chk(d1[15:8] == arr[15:8] && d1[5:0] == arr[5:0], "R9 other bits prog", d1, arr);
    do_read(16'h0042, d2);
    chk(d2[6] != d1[6], "R8 toggle consecutive", d2[6], !d1[6]);
    // held strobe counts as one access
    @(negedge clk); rd = 1; #1 d3 = rdata;
    repeat (3) @(negedge clk);
    rd = 0;
    do_read(16'h0042, d4);
    chk(d3[6] != d2[6], "R8 toggle held first", d3[6], !d2[6]);
    chk(d4[6] != d3[6], "R8 toggle held once", d4[6], !d3[6]);
    wait_idle();
    launch(2'b00, 16'h0080);
    do_read(16'h0001, d1);
    chk(d1[7] == 1'b0, "R6 bit7 complement of 1", d1[7], 0);
    wait_idle();
  endtask

  task automatic t_erase_status();
    logic [15:0] d1, d2;
    arr = 16'hFFFF;
    launch(2'b01, 16'h0080);
    do_read(16'h0800, d1);
    chk(d1[7] == 1'b0, "R7 sector erase bit7", d1[7], 0);
    chk(d1[15:8] == 8'hFF && d1[5:0] == 6'h3F, "R9 other bits erase", d1, arr);
    do_read(16'h0800, d2);
    chk(d2[6] != d1[6], "R8 toggle erase", d2[6], !d1[6]);
    wait_idle();
    do_read(16'h0800, d1);
    do_read(16'h0800, d2);
    chk(d1 == 16'hFFFF, "R10 erased reads all ones", d1, 16'hFFFF);
    chk(d2[6] == d1[6], "R10 toggle stopped", d2[6], d1[6]);
    arr = 16'h1234;
    launch(2'b10, 16'h0);
    do_read(16'h0003, d1);
    chk(d1[7] == 1'b0, "R7 chip erase bit7", d1[7], 0);
    wait_idle();
  endtask

  task automatic t_id_mode();
    logic [15:0] d;
    arr = 16'h4D2E;
    id_mode = 1;
    do_read(16'h0000, d); chk(d == MFR, "R11 id word 0", d, MFR);
    do_read(16'h0001, d); chk(d == DEV, "R11 id word 1", d, DEV);
    do_read(16'h0002, d); chk(d == arr, "R11 other address", d, arr);
    launch(2'b00, 16'h0000);
    do_read(16'h0000, d);
    chk(d[7] == 1'b1 && d[15:8] == arr[15:8], "R12 status over id", d, {arr[15:8], 8'h80});
    wait_idle();
    id_mode = 0;
    do_read(16'h0000, d); chk(d == arr, "R10 plain read after", d, arr);
  endtask

  initial begin
    #(CLK_T * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_reserved();
    t_restart();
    t_prog_status();
    t_erase_status();
    t_id_mode();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule